// File: doc/BRIEF.md
# Oscillator Frequency Reprogramming Sequencer

This block sits on the controller side of a serial register bus and retunes a remote clock generator. A request carries the PLL feedback divider as a 7-bit integer part N and a 17-bit fraction F. It also carries one or two 8-bit output dividers M1 and M2, and a flag that says whether the target has two outputs. The block turns an accepted request into a fixed chain of single-byte register writes. It hands these writes one at a time to a bus master through a valid/ready command port.

The chain has four parts. First the block sets the low-power bit (bit 5) of control register 0x10. It then waits out a settling time of at least 100 µs, counted in system clock cycles. Next it writes the divider registers from 0x13 upward. Last it clears the low-power bit. The block checks each request before any traffic starts. A request with an output divider below 2, or a request made while the target's master enable is low, is refused. The block then raises a one-cycle error pulse and sends nothing on the bus.

Top module: `osc_reprog_seq`

## Requirements
- R1: After reset, busy_o, cmd_valid_o, done_o and error_o are all 0.
- R2: The first write of an accepted request goes to address 0x10 with data 0x20, which sets bit 5.
- R3: The next write becomes valid exactly WAIT_CYC cycles after the clock edge that accepts the 0x10/0x20 write. WAIT_CYC = ceil(CLK_FREQ_HZ × WAIT_US / 1e6), which is 5000 with the default parameters.
- R4: The divider writes go out in ascending address order: 0x13 = F[7:0], 0x14 = F[15:8], 0x15 = {N[6:0], F[16]}, 0x16 = M1.
- R5: When dual_i is 1, a write to 0x17 with M2 follows 0x16. When dual_i is 0, no write to 0x17 is issued.
- R6: The last write goes to 0x10 with data 0x00. In the cycle after it is accepted, done_o is 1 for exactly one cycle and busy_o is 0.
- R7: While cmd_valid_o is high and cmd_ready_i is low, cmd_valid_o, cmd_addr_o and cmd_data_o hold steady. Each register write is issued exactly once.
- R8: The block refuses a request in either of two cases: M1 is below 2, or dual_i is 1 and M2 is below 2. On a refusal, error_o pulses for one cycle, no write is issued, and busy_o stays 0. In single mode the value of M2 is not checked.
- R9: A request made while target_en_i is 0 is refused in the same way: an error pulse and no writes.
- R10: A request made while busy_o is 1 has no effect on the writes that are in progress.
- R11: busy_o is 1 from the cycle after a request is accepted until the final write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, sampled while idle |
| req_n_i | input | 7 | Integer part of the feedback divider |
| req_f_i | input | 17 | Fractional part of the feedback divider |
| req_m1_i | input | 8 | Output divider 1 |
| req_m2_i | input | 8 | Output divider 2 (used when dual) |
| req_dual_i | input | 1 | Target has two outputs |
| target_en_i | input | 1 | Target master enable level |
| cmd_valid_o | output | 1 | Register write pending |
| cmd_ready_i | input | 1 | Bus master accepts the write |
| cmd_addr_o | output | 8 | Register address |
| cmd_data_o | output | 8 | Register data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | One-cycle refusal pulse |

## Verification
The bench measures the settling gap to the exact cycle. A timer with an off-by-one error, or a timer that starts when the write is issued rather than when it is accepted, moves the first divider write and is caught.

It packs F[16] together with a full N at the boundary value. A design that mixes up the bit lanes of 0x15 writes the wrong byte there.

It also covers several other corner cases:
- It stalls the ready line. A design that ignores backpressure then skips or repeats addresses.
- It tries M values of 1 and 0 in dual mode, and a zero M2 in single mode. A wrong range check either refuses a legal request or starts a sequence that should have been refused.
- It sends a second request in the middle of a sequence. A design that does not ignore it would restart the sequence or corrupt the divider data.

// File: rtl/osc_reprog_pkg.sv
package osc_reprog_pkg;
  localparam int N_W   = 7;
  localparam int F_W   = 17;
  localparam int M_W   = 8;
  localparam int IDX_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HIB_ON,
    ST_SETTLE,
    ST_DIV_WR,
    ST_HIB_OFF
  } seq_state_e;

  typedef struct packed {
    logic [N_W-1:0] n;
    logic [F_W-1:0] f;
    logic [M_W-1:0] m1;
    logic [M_W-1:0] m2;
    logic           dual;
  } pll_cfg_t;
endpackage

// File: rtl/osc_hib_timer.sv
module osc_hib_timer #(
  parameter int CYC = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expired_o
);
  localparam int CNT_W = (CYC < 2) ? 1 : $clog2(CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(CYC - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/osc_req_check.sv
module osc_req_check
  import osc_reprog_pkg::*;
#(
  parameter int M_MIN = 2
) (
  input  pll_cfg_t cfg_i,
  input  logic     target_en_i,
  output logic     ok_o
);
  logic m1_ok, m2_ok;

  assign m1_ok = cfg_i.m1 >= M_W'(M_MIN);
  assign m2_ok = !cfg_i.dual || (cfg_i.m2 >= M_W'(M_MIN));
  assign ok_o  = target_en_i && m1_ok && m2_ok;
endmodule

// File: rtl/osc_div_table.sv
module osc_div_table
  import osc_reprog_pkg::*;
#(
  parameter logic [7:0] DIV_BASE = 8'h13,
  parameter int         NUM_REG  = 5
) (
  input  logic [IDX_W-1:0] idx_i,
  input  pll_cfg_t         cfg_i,
  output logic [7:0]       addr_o,
  output logic [7:0]       data_o
);
  logic [7:0] bytes [NUM_REG];

  // Byte lanes: fraction low, fraction mid, {integer, fraction msb}, output dividers.
  assign bytes[0] = cfg_i.f[7:0];
  assign bytes[1] = cfg_i.f[15:8];
  assign bytes[2] = {cfg_i.n, cfg_i.f[16]};
  assign bytes[3] = cfg_i.m1;
  assign bytes[4] = cfg_i.m2;

  assign addr_o = DIV_BASE + 8'(idx_i);

  always_comb begin
    data_o = 8'h00;
    for (int i = 0; i < NUM_REG; i++)
      if (idx_i == IDX_W'(i)) data_o = bytes[i];
  end
endmodule

// File: rtl/osc_reprog_seq.sv
module osc_reprog_seq
  import osc_reprog_pkg::*;
#(
  parameter int         CLK_FREQ_HZ = 50_000_000,
  parameter int         WAIT_US     = 100,
  parameter logic [7:0] CTRL_ADDR   = 8'h10,
  parameter int         HIB_BIT     = 5,
  parameter logic [7:0] DIV_BASE    = 8'h13,
  parameter int         M_MIN       = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  input  logic [N_W-1:0] req_n_i,
  input  logic [F_W-1:0] req_f_i,
  input  logic [M_W-1:0] req_m1_i,
  input  logic [M_W-1:0] req_m2_i,
  input  logic           req_dual_i,
  input  logic           target_en_i,
  output logic           cmd_valid_o,
  input  logic           cmd_ready_i,
  output logic [7:0]     cmd_addr_o,
  output logic [7:0]     cmd_data_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           error_o
);
  localparam int WAIT_CYC = ((CLK_FREQ_HZ / 1000) * WAIT_US + 999) / 1000;
  localparam int NUM_REG  = 5;
  localparam logic [7:0] HIB_SET = 8'(1) << HIB_BIT;

  seq_state_e       state_q;
  pll_cfg_t         cfg_q, req_cfg;
  logic [IDX_W-1:0] idx_q, last_idx;
  logic             req_ok, accept, hs, tmr_start, tmr_exp;
  logic             done_q, error_q;
  logic [7:0]       div_addr, div_data;

  assign req_cfg = '{n: req_n_i, f: req_f_i, m1: req_m1_i, m2: req_m2_i, dual: req_dual_i};

  osc_req_check #(.M_MIN(M_MIN)) chk_i (
    .cfg_i       (req_cfg),
    .target_en_i (target_en_i),
    .ok_o        (req_ok)
  );

  osc_div_table #(.DIV_BASE(DIV_BASE), .NUM_REG(NUM_REG)) tbl_i (
    .idx_i  (idx_q),
    .cfg_i  (cfg_q),
    .addr_o (div_addr),
    .data_o (div_data)
  );

  osc_hib_timer #(.CYC(WAIT_CYC)) tmr_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (tmr_start),
    .expired_o (tmr_exp)
  );

  assign accept    = req_valid_i && (state_q == ST_IDLE);
  assign hs        = cmd_valid_o && cmd_ready_i;
  assign tmr_start = (state_q == ST_HIB_ON) && hs;
  assign last_idx  = cfg_q.dual ? IDX_W'(NUM_REG - 1) : IDX_W'(NUM_REG - 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      error_q <= 1'b0;
    end else begin
      done_q  <= (state_q == ST_HIB_OFF) && hs;
      error_q <= accept && !req_ok;
      unique case (state_q)
        ST_IDLE: if (accept && req_ok) begin
          cfg_q   <= req_cfg;
          state_q <= ST_HIB_ON;
        end
        ST_HIB_ON:  if (hs) state_q <= ST_SETTLE;
        ST_SETTLE: if (tmr_exp) begin
          idx_q   <= '0;
          state_q <= ST_DIV_WR;
        end
        ST_DIV_WR: if (hs) begin
          if (idx_q == last_idx) state_q <= ST_HIB_OFF;
          else                   idx_q   <= idx_q + 1'b1;
        end
        ST_HIB_OFF: if (hs) state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_valid_o = 1'b0;
    cmd_addr_o  = CTRL_ADDR;
    cmd_data_o  = 8'h00;
    unique case (state_q)
      ST_HIB_ON: begin
        cmd_valid_o = 1'b1;
        cmd_data_o  = HIB_SET;
      end
      ST_DIV_WR: begin
        cmd_valid_o = 1'b1;
        cmd_addr_o  = div_addr;
        cmd_data_o  = div_data;
      end
      ST_HIB_OFF: cmd_valid_o = 1'b1;
      default: ;
    endcase
  end

  assign busy_o  = state_q != ST_IDLE;
  assign done_o  = done_q;
  assign error_o = error_q;
endmodule

// File: rtl/osc_reprog_sva.sv
module osc_reprog_sva #(
  parameter int         CLK_FREQ_HZ = 50_000_000,
  parameter int         WAIT_US     = 100,
  parameter logic [7:0] CTRL_ADDR   = 8'h10,
  parameter logic [7:0] DIV_BASE    = 8'h13
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       cmd_valid_o,
  input logic       cmd_ready_i,
  input logic [7:0] cmd_addr_o,
  input logic [7:0] cmd_data_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       error_o
);
  localparam int WAIT_CYC = ((CLK_FREQ_HZ / 1000) * WAIT_US + 999) / 1000;
  localparam int GW       = $clog2(WAIT_CYC + 2);

  logic [GW-1:0] gap_q;
  logic          hib_hs;

  assign hib_hs = cmd_valid_o && cmd_ready_i && (cmd_addr_o == CTRL_ADDR) && (cmd_data_o != 8'h00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     gap_q <= '0;
    else if (hib_hs)                 gap_q <= '0;
    else if (gap_q != GW'(WAIT_CYC)) gap_q <= gap_q + 1'b1;
  end

  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_data_o)); // R7
  AST_SETTLE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && (cmd_addr_o == DIV_BASE) |-> gap_q >= GW'(WAIT_CYC)); // R3
  AST_DONE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R6
  AST_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !busy_o && !cmd_valid_o); // R8
  AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cmd_valid_o); // R11
  AST_M1_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && (cmd_addr_o == DIV_BASE + 8'd3) |-> cmd_data_o >= 8'd2); // R8
  AST_BUSY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && req_valid_i && !(cmd_valid_o && cmd_ready_i) |=> busy_o); // R10
endmodule

bind osc_reprog_seq osc_reprog_sva #(
  .CLK_FREQ_HZ(CLK_FREQ_HZ), .WAIT_US(WAIT_US), .CTRL_ADDR(CTRL_ADDR), .DIV_BASE(DIV_BASE)
) sva_i (.*);

// File: tb/osc_reprog_seq_tb_top.sv
module osc_reprog_seq_tb_top;
  localparam int WAIT_CYC = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [6:0]  req_n = '0;
  logic [16:0] req_f = '0;
  logic [7:0]  req_m1 = '0, req_m2 = '0;
  logic        req_dual = 1'b0, target_en = 1'b1;
  logic        cmd_valid, cmd_ready = 1'b0;
  logic [7:0]  cmd_addr, cmd_data;
  logic        busy, done, error;

  int n_chk = 0, n_bad = 0;
  int stall_len = 0, stall_cnt = 0;
  int rec_n = 0, done_n = 0, err_n = 0, cyc = 0;
  logic [7:0] rec_a [32];
  logic [7:0] rec_d [32];
  int         rec_c [32];
  logic [7:0] exp_a [8];
  logic [7:0] exp_d [8];
  int         exp_n = 0;

  always #10 clk = ~clk;

  osc_reprog_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_n_i(req_n), .req_f_i(req_f),
    .req_m1_i(req_m1), .req_m2_i(req_m2), .req_dual_i(req_dual), .target_en_i(target_en),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data),
    .busy_o(busy), .done_o(done), .error_o(error)
  );

  // Bus master model and write logger, all at the falling edge.
  initial forever begin
    @(negedge clk);
    cyc++;
    if (done)  done_n++;
    if (error) err_n++;
    if (cmd_valid && stall_cnt >= stall_len) begin
      if (rec_n < 32) begin
        rec_a[rec_n] = cmd_addr;
        rec_d[rec_n] = cmd_data;
        rec_c[rec_n] = cyc;
      end
      rec_n++;
      cmd_ready = 1'b1;
      stall_cnt = 0;
    end else if (cmd_valid) begin
      cmd_ready = 1'b0;
      stall_cnt++;
    end else begin
      cmd_ready = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk);
    rec_n = 0; done_n = 0; err_n = 0;
  endtask

  task automatic send(input logic [6:0] n, input logic [16:0] f, input logic [7:0] m1,
                      input logic [7:0] m2, input logic dual);
    @(negedge clk);
    req_n = n; req_f = f; req_m1 = m1; req_m2 = m2; req_dual = dual;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 20000 && busy; t++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Expected write list from R2, R4, R5, R6.
  task automatic build_exp(input logic [6:0] n, input logic [16:0] f, input logic [7:0] m1,
                           input logic [7:0] m2, input logic dual);
    exp_n = 0;
    exp_a[exp_n] = 8'h10; exp_d[exp_n] = 8'h20;       exp_n++;
    exp_a[exp_n] = 8'h13; exp_d[exp_n] = f[7:0];      exp_n++;
    exp_a[exp_n] = 8'h14; exp_d[exp_n] = f[15:8];     exp_n++;
    exp_a[exp_n] = 8'h15; exp_d[exp_n] = {n, f[16]};  exp_n++;
    exp_a[exp_n] = 8'h16; exp_d[exp_n] = m1;          exp_n++;
    if (dual) begin
      exp_a[exp_n] = 8'h17; exp_d[exp_n] = m2;        exp_n++;
    end
    exp_a[exp_n] = 8'h10; exp_d[exp_n] = 8'h00;       exp_n++;
  endtask

  task automatic cmp_writes(input string tag);
    chk(rec_n == exp_n, {tag, " R5 R7 write count"}, rec_n, exp_n);
    for (int i = 0; i < exp_n && i < rec_n; i++) begin
      chk(rec_a[i] == exp_a[i], {tag, " R4 addr"}, rec_a[i], exp_a[i]);
      chk(rec_d[i] == exp_d[i], {tag, " R4 data"}, rec_d[i], exp_d[i]);
    end
    chk(done_n == 1, {tag, " R6 done pulse count"}, done_n, 1);
    chk(err_n == 0, {tag, " R8 no error"}, err_n, 0);
    chk(!busy, {tag, " R6 idle after"}, busy, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !cmd_valid && !done && !error, "R1 reset outputs", {busy, cmd_valid, done, error}, 0);
  endtask

  task automatic t_dual_fast();
    stall_len = 0;
    clear_log();
    build_exp(7'd69, 17'h0E38E, 8'd5, 8'd25, 1'b1);
    send(7'd69, 17'h0E38E, 8'd5, 8'd25, 1'b1);
    chk(busy, "R11 busy after accept", busy, 1);
    wait_idle();
    chk(rec_a[0] == 8'h10 && rec_d[0] == 8'h20, "R2 hibernate enter", rec_d[0], 8'h20);
    chk(rec_c[1] - rec_c[0] == WAIT_CYC + 1, "R3 settle gap", rec_c[1] - rec_c[0], WAIT_CYC + 1);
    chk(rec_a[6] == 8'h10 && rec_d[6] == 8'h00, "R6 hibernate exit", rec_d[6], 8'h00);
    cmp_writes("dual");
  endtask

  task automatic t_single_stall();
    stall_len = 2;
    clear_log();
    build_exp(7'd127, 17'h1FFFF, 8'd2, 8'd0, 1'b0);
    send(7'd127, 17'h1FFFF, 8'd2, 8'd0, 1'b0);
    wait_idle();
    chk(rec_n == 6, "R5 no 0x17 in single mode", rec_n, 6);
    chk(rec_d[3] == 8'hFF, "R4 packed 0x15 boundary", rec_d[3], 8'hFF);
    cmp_writes("single");
    stall_len = 0;
  endtask

  task automatic t_bad_m();
    clear_log();
    send(7'd66, 17'h15555, 8'd1, 8'd24, 1'b1);
    wait_idle();
    chk(err_n == 1 && rec_n == 0 && !busy, "R8 M1 below 2 refused", err_n, 1);
    clear_log();
    send(7'd66, 17'h15555, 8'd24, 8'd0, 1'b1);
    wait_idle();
    chk(err_n == 1 && rec_n == 0 && !busy, "R8 M2 zero refused in dual", err_n, 1);
  endtask

  task automatic t_no_enable();
    clear_log();
    target_en = 1'b0;
    send(7'd66, 17'h15555, 8'd24, 8'd24, 1'b1);
    wait_idle();
    target_en = 1'b1;
    chk(err_n == 1, "R9 error when enable low", err_n, 1);
    chk(rec_n == 0, "R9 no writes when enable low", rec_n, 0);
  endtask

  task automatic t_busy_ignore();
    stall_len = 0;
    clear_log();
    build_exp(7'd66, 17'h15555, 8'd24, 8'd25, 1'b1);
    send(7'd66, 17'h15555, 8'd24, 8'd25, 1'b1);
    repeat (10) @(negedge clk);
    send(7'd88, 17'h1C71C, 8'd3, 8'd7, 1'b0);
    chk(busy, "R10 still busy after second request", busy, 1);
    wait_idle();
    cmp_writes("busy_ignore R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_dual_fast();
    t_single_stall();
    t_bad_m();
    t_no_enable();
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(150_000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule